// File: doc/BRIEF.md
# Unused Data-Flow Pair Tracker

This block watches a fixed set of source-to-sink signal pairs while a test runs. It reports the pairs whose intermediate logic never changed the value carried from source to sink. Each pair has a source word, a sink word and a per-pair alignment delay of 0 to 3 evaluated cycles.

The block starts with every pair marked live, meaning still suspicious. On each evaluated cycle it compares each sink with the source value from the pair's delay in the past. The first time they differ, the pair's live bit is cleared for good. A pair that survives a whole run behaves like a wire, possibly followed by delay registers, as far as the tests can tell. The logic between its source and sink is therefore a candidate for removal.

The set of pairs is built outside the block and wired to its ports. A registered population count reports how many pairs are still live.

Top module: `flowpair_monitor`

## Requirements
- R1: After reset, `live_mask` is all ones and `live_count` equals NUM_PAIRS.
- R2: While `run_en` is high, a pair whose sink differs from its aligned source has its live bit cleared at the next clock edge.
- R3: Equality never clears a live bit. A cleared bit stays cleared until `clear` or reset.
- R4: Pair p takes its delay from `dly_bus[2p+1:2p]` (0 to 3). The sink is compared with the source value presented that many evaluated cycles earlier, and a delay of 0 compares with the current source.
- R5: After reset or `clear`, a pair with delay d is not compared until d evaluated cycles have filled its history.
- R6: While `run_en` is low and `clear` is low, no live bit changes and the source history does not advance.
- R7: `clear` sets every live bit at the next edge and empties all histories. It takes priority over `run_en`.
- R8: `live_count` equals the number of ones that `live_mask` held one cycle earlier.
- R9: Consider a four-way selector whose second data input reaches the output only for control code 11. Its pairs are evaluated under control codes 00, 01 and 10 with distinct data. Only the pair from the normal input to the output stays live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Evaluate pairs and advance histories this cycle |
| clear | input | 1 | Restore all live bits and empty histories |
| src_bus | input | NUM_PAIRS*DATA_W | Source words, pair p at `[p*DATA_W +: DATA_W]` |
| snk_bus | input | NUM_PAIRS*DATA_W | Sink words, same packing |
| dly_bus | input | 2*NUM_PAIRS | Per-pair alignment delay, pair p at `[2p +: 2]` |
| live_mask | output | NUM_PAIRS | One bit per pair still unpruned |
| live_count | output | $clog2(NUM_PAIRS+1) | Registered count of live pairs |

## Verification
The first pattern is the eight pairs of a selector netlist driven under three of its four control codes. It separates pruning by value inequality from mere exercise of every path: only the pair from the normal input to the output may survive.

The second pattern is a random stream sent through bench-side delay lines of depth 0, 2 and 3, with one pair given a deliberately wrong delay. It shows whether the history is aligned to evaluated cycles. It also shows whether unfilled history stages are skipped, because one pair carries mismatching data only during the fill window.

Two short patterns then set mismatches against `run_en` low and against `clear`. They show whether the enable gates pruning and whether clear wins.

// File: rtl/flowpair_pkg.sv
package flowpair_pkg;
  localparam int HIST_DEPTH = 3;
  localparam int DLY_W      = 2;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/fpm_history.sv
module fpm_history
  import flowpair_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              flush,
  input  logic [DATA_W-1:0] src,
  input  dly_t              dly,
  output logic [DATA_W-1:0] aligned_src,
  output logic              aligned_ok
);
  logic [DATA_W-1:0] hist_q [HIST_DEPTH];
  logic [DATA_W-1:0] hist_d [HIST_DEPTH];
  logic [1:0]        fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    for (int i = 0; i < HIST_DEPTH; i++) hist_d[i] = hist_q[i];
    if (flush) begin
      fill_d = '0;
    end else if (adv) begin
      hist_d[0] = src;
      for (int i = 1; i < HIST_DEPTH; i++) hist_d[i] = hist_q[i-1];
      if (fill_q != 2'd3) fill_d = fill_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) hist_q[i] <= '0;
    end else begin
      fill_q <= fill_d;
      for (int i = 0; i < HIST_DEPTH; i++) hist_q[i] <= hist_d[i];
    end
  end

  always_comb begin
    case (dly)
      2'd0:    aligned_src = src;
      2'd1:    aligned_src = hist_q[0];
      2'd2:    aligned_src = hist_q[1];
      default: aligned_src = hist_q[2];
    endcase
    aligned_ok = (fill_q >= dly);
  end

  // R5: fill level only moves up, one step per evaluated cycle, unless flushed
  assert_fill_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (fill_q == $past(fill_q)) || (fill_q == $past(fill_q) + 2'd1));
  // R6: history frozen without advance
  assert_hist_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !flush) |=> $stable(fill_q) && $stable(hist_q[0]));
endmodule

// File: rtl/fpm_pair_cell.sv
module fpm_pair_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic              flush,
  input  logic [DATA_W-1:0] sink,
  input  logic [DATA_W-1:0] ref_val,
  input  logic              ref_ok,
  output logic              live
);
  logic live_q, live_d, differ;

  always_comb begin
    differ = eval && ref_ok && (sink != ref_val);
    live_d = live_q;
    if (flush)       live_d = 1'b1;
    else if (differ) live_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b1;
    else        live_q <= live_d;
  end

  assign live = live_q;

  // R2: an evaluated inequality prunes the pair
  assert_prune_on_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && eval && ref_ok && sink != ref_val) |=> !live_q);
  // R3: equality alone never prunes
  assert_keep_on_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && eval && ref_ok && sink == ref_val) |=> live_q == $past(live_q));
endmodule

// File: rtl/fpm_popcount.sv
module fpm_popcount #(
  parameter int N     = 8,
  parameter int CNT_W = $clog2(N+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < N; i++) cnt_d = cnt_d + CNT_W'(bits[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(N);
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/flowpair_monitor.sv
module flowpair_monitor
  import flowpair_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = $clog2(NUM_PAIRS+1),
  localparam int BUS_W    = NUM_PAIRS*DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 clear,
  input  logic [BUS_W-1:0]     src_bus,
  input  logic [BUS_W-1:0]     snk_bus,
  input  logic [2*NUM_PAIRS-1:0] dly_bus,
  output logic [NUM_PAIRS-1:0] live_mask,
  output logic [CNT_W-1:0]     live_count
);
  logic adv;
  assign adv = run_en && !clear;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [DATA_W-1:0] aligned;
    logic              aligned_ok;

    fpm_history #(.DATA_W(DATA_W)) u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (adv),
      .flush       (clear),
      .src         (src_bus[p*DATA_W +: DATA_W]),
      .dly         (dly_bus[p*DLY_W +: DLY_W]),
      .aligned_src (aligned),
      .aligned_ok  (aligned_ok)
    );

    fpm_pair_cell #(.DATA_W(DATA_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .eval    (adv),
      .flush   (clear),
      .sink    (snk_bus[p*DATA_W +: DATA_W]),
      .ref_val (aligned),
      .ref_ok  (aligned_ok),
      .live    (live_mask[p])
    );
  end

  fpm_popcount #(.N(NUM_PAIRS), .CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (live_mask),
    .count (live_count)
  );

  // R3: no live bit rises except through clear
  assert_no_revive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (live_mask & ~$past(live_mask)) == '0);
  // R7: clear restores every pair
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> &live_mask);
  // R6: nothing changes while disabled
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clear) |=> $stable(live_mask));
  // R8: count trails the mask by one cycle
  assert_count_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> live_count == CNT_W'($countones($past(live_mask))));
endmodule

// File: tb/test_flowpair_monitor.sv
module test_flowpair_monitor;
  localparam int NP = 8;
  localparam int DW = 8;
  localparam int CW = $clog2(NP+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic clear = 1'b0;
  logic [DW-1:0] src_v [NP];
  logic [DW-1:0] snk_v [NP];
  logic [1:0]    dly_v [NP];
  logic [NP*DW-1:0] src_bus, snk_bus;
  logic [2*NP-1:0]  dly_bus;
  logic [NP-1:0] live_mask;
  logic [CW-1:0] live_count;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      src_bus[p*DW +: DW] = src_v[p];
      snk_bus[p*DW +: DW] = snk_v[p];
      dly_bus[p*2 +: 2]   = dly_v[p];
    end
  end

  flowpair_monitor #(.NUM_PAIRS(NP), .DATA_W(DW)) i_flowpair_monitor (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .clear(clear),
    .src_bus(src_bus), .snk_bus(snk_bus), .dly_bus(dly_bus),
    .live_mask(live_mask), .live_count(live_count));

  // behavioural reference model
  logic [NP-1:0] m_live;
  int            m_cnt;
  logic [DW-1:0] m_hist [NP][3];
  int            m_fill;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = '1; m_cnt = NP; m_fill = 0;
    end else begin
      m_cnt = $countones(m_live);
      if (clear) begin
        m_live = '1; m_fill = 0;
      end else if (run_en) begin
        for (int p = 0; p < NP; p++) begin
          int d;
          logic [DW-1:0] r;
          d = int'(dly_v[p]);
          r = (d == 0) ? src_v[p] : m_hist[p][d-1];
          if (m_fill >= d && r != snk_v[p]) m_live[p] = 1'b0;
        end
        for (int p = 0; p < NP; p++) begin
          m_hist[p][2] = m_hist[p][1];
          m_hist[p][1] = m_hist[p][0];
          m_hist[p][0] = src_v[p];
        end
        if (m_fill < 3) m_fill++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // waits one cycle and compares against the model (R8 count, mask per R2..R7)
  task automatic cyc();
    @(negedge clk);
    check(live_mask == m_live, "R2 model mask", int'(live_mask), int'(m_live));
    check(int'(live_count) == m_cnt, "R8 model count", int'(live_count), m_cnt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  logic [DW-1:0] sp [4];

  initial begin
    for (int p = 0; p < NP; p++) begin src_v[p] = '0; snk_v[p] = '0; dly_v[p] = '0; end
    for (int i = 0; i < 4; i++) sp[i] = '0;
    repeat (3) @(negedge clk);
    check(live_mask == '1, "R1 reset mask", int'(live_mask), 'hFF);
    check(live_count == CW'(NP), "R1 reset count", int'(live_count), NP);
    rst_n = 1'b1;
    cyc();

    // R9 selector pattern: pairs (G,X)(A,X)(G,Y)(A,Y)(G,Out)(A,Out)(X,Out)(Y,Out)
    run_en = 1'b1;
    for (int ctl = 0; ctl < 3; ctl++) begin
      for (int k = 0; k < 3; k++) begin
        logic [DW-1:0] g, a, x, y, o;
        g = DW'($urandom); a = ~g;
        x = ctl[1] ? a : g; y = ctl[0] ? a : g; o = g;
        src_v[0] = g; snk_v[0] = x;  src_v[1] = a; snk_v[1] = x;
        src_v[2] = g; snk_v[2] = y;  src_v[3] = a; snk_v[3] = y;
        src_v[4] = g; snk_v[4] = o;  src_v[5] = a; snk_v[5] = o;
        src_v[6] = x; snk_v[6] = o;  src_v[7] = y; snk_v[7] = o;
        cyc();
      end
    end
    run_en = 1'b0;
    cyc(); cyc();
    check(live_mask == 8'h10, "R9 selector survivor", int'(live_mask), 'h10);
    check(live_count == CW'(1), "R9 selector count", int'(live_count), 1);

    // R6: mismatches while disabled after clear
    clear = 1'b1; cyc(); clear = 1'b0;
    for (int p = 0; p < NP; p++) begin src_v[p] = 8'h0F; snk_v[p] = 8'hF0; end
    repeat (4) cyc();
    check(live_mask == '1, "R6 disabled no prune", int'(live_mask), 'hFF);

    // R7: clear wins over run_en with mismatches present
    run_en = 1'b1; cyc();
    check(live_mask == '0, "R2 all pruned", int'(live_mask), 0);
    clear = 1'b1; cyc(); clear = 1'b0; run_en = 1'b0;
    check(live_mask == '1, "R7 clear priority", int'(live_mask), 'hFF);
    cyc();

    // R4/R5 delay alignment
    dly_v[0] = 2'd2; dly_v[1] = 2'd1; dly_v[2] = 2'd3; dly_v[3] = 2'd0;
    dly_v[4] = 2'd0; dly_v[5] = 2'd3; dly_v[6] = 2'd0; dly_v[7] = 2'd0;
    run_en = 1'b1;
    for (int n = 0; n < 12; n++) begin
      logic [DW-1:0] s;
      s = DW'($urandom);
      sp[3] = sp[2]; sp[2] = sp[1]; sp[1] = sp[0]; sp[0] = s;
      for (int p = 0; p < 4; p++) src_v[p] = s;
      snk_v[0] = sp[2]; snk_v[1] = (sp[2] == sp[1]) ? ~sp[2] : sp[2];
      snk_v[2] = sp[3]; snk_v[3] = s;
      src_v[4] = 8'h00; snk_v[4] = (n == 6) ? 8'h01 : 8'h00;
      src_v[5] = s; snk_v[5] = (n < 3) ? ~sp[3] : sp[3];
      src_v[6] = 8'h00; snk_v[6] = 8'h00; src_v[7] = 8'h00; snk_v[7] = 8'h00;
      cyc();
    end
    run_en = 1'b0;
    cyc(); cyc();
    check(live_mask == 8'hED, "R4 delay alignment", int'(live_mask), 'hED);
    check(live_mask[5] == 1'b1, "R5 unfilled stage skipped", int'(live_mask[5]), 1);
    check(live_mask[4] == 1'b0, "R3 pruned bit stays cleared", int'(live_mask[4]), 0);
    check(live_count == CW'(6), "R8 final count", int'(live_count), 6);
    finish_run();
  end
endmodule